// File: doc/BRIEF.md
# Oversampled Data Alignment Deserializer

This block sits behind a receiver front end that takes two samples per bit: one at the centre of the bit (a data sample) and one at the transition between bits (an edge sample). Every beat of the fast parallel clock delivers four samples that cover two bits in a row. The block passes the beat through two retiming registers to guard against metastability. It then pairs each edge sample with the two data bits on either side of it. Last, it gathers the aligned stream in two steps, 2:4 and then 1:5. The result is a 20-bit data word and a 20-bit edge word, aligned bit for bit, which a downstream phase detector reads together.

The whole block runs on the beat clock. A one-cycle word strobe marks each new word, once every ten beats. The strobe serves as the enable for the divided word rate, so no second clock domain is needed inside the block. A synchronous active-low reset restarts all stage counters. The first beat sampled after reset is released becomes bit 0 of the first word.

Top module: `ovs_deser`

## Requirements
- R1: Input beat packing is `samp_i[0]` = edge sample before the earlier bit, `samp_i[1]` = data sample of the earlier bit, `samp_i[2]` = edge sample before the later bit, `samp_i[3]` = data sample of the later bit. In `data_word_o`, bit 0 is the earliest received bit, and bit i of word k is stream bit 20k+i.
- R2: Bit i of `edge_word_o` is the edge sample taken between data bits i and i+1 of the same word. For the last bit, this is the edge sample that opens the first bit of the next word.
- R3: Counting the first rising edge with `rst_n` high as edge 0, the first `word_valid_o` pulse is seen right after edge 13. This latency includes the two retiming stages.
- R4: `word_valid_o` is high for exactly one cycle per word, and successive pulses are exactly 10 cycles apart.
- R5: While `rst_n` is low, `word_valid_o` is low and both words are zero. The strobe stays low until a first full word has been assembled.
- R6: `data_word_o` and `edge_word_o` change only in a cycle where `word_valid_o` is high, and hold between strobes.
- R7: Asserting reset in the middle of a stream discards the partial word. After release, word alignment restarts from the first beat sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, one beat of four samples per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_i | input | 4 | Edge/data sample beat covering two bits |
| data_word_o | output | 20 | Assembled data samples, bit 0 earliest |
| edge_word_o | output | 20 | Assembled edge samples aligned to the data word |
| word_valid_o | output | 1 | One-cycle strobe when a new word pair is presented |

## Verification
The assertions assume that a beat is present on every clock cycle once reset is released. The input has no valid qualifier and no gaps, so the strobe spacing and first-word latency follow directly from the clock count. The bench keeps to that: it drives a new beat on every falling edge without pause, mixing seeded random beats with runs of all zeros, all ones, alternating patterns and single set samples. It also applies a reset in the middle of a stream so that restart alignment is exercised.

// File: rtl/ovs_deser_pkg.sv
// Package: shared constants for the oversampled alignment deserializer.
// Assumes two samples per bit (one edge, one data) and a packing where
// each bit's edge sample sits just below its data sample in the beat.
package ovs_deser_pkg;
    localparam int SAMPLES_PER_BIT = 2;
    localparam int DEF_BEAT_BITS   = 2;
    localparam int DEF_MID_RATIO   = 2;
    localparam int DEF_WORD_RATIO  = 5;
    localparam int SYNC_STAGES     = 2;
endpackage

// File: rtl/ovs_resync.sv
// Module: two-register retiming of the incoming sample beat.
// Assumes the beat may be captured near a transition; the datapath is not
// reset, only the valid marker that travels with it is cleared by reset.
module ovs_resync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] beat_i,
    output logic [W-1:0] beat_o,
    output logic         vld_o
);
    logic [W-1:0] stg1_q;
    logic [W-1:0] stg2_q;
    logic         v1_q;
    logic         v2_q;

    // Two-stage capture of the sample beat.
    always_ff @(posedge clk) begin
        stg1_q <= beat_i;
        stg2_q <= stg1_q;
    end

    // Valid marker follows the beat through both stages after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
        end else begin
            v1_q <= 1'b1;
            v2_q <= v1_q;
        end
    end

    assign beat_o = stg2_q;
    assign vld_o  = v2_q;
endmodule

// File: rtl/ovs_align.sv
// Module: splits a retimed beat into data bits and edge bits, pairing each
// edge with the transition that follows its data bit.
// Assumes beat bit 2i is the edge before bit i and bit 2i+1 is data bit i.
// The edge after the last bit of a beat is in the next beat, so output is
// taken from the held previous beat and is one beat late.
module ovs_align #(
    parameter int BEAT_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*BEAT_BITS-1:0] beat_i,
    input  logic                 vld_i,
    output logic [BEAT_BITS-1:0] dat_o,
    output logic [BEAT_BITS-1:0] edg_o,
    output logic                 vld_o
);
    logic [2*BEAT_BITS-1:0] prev_q;
    logic                   have_prev_q;

    // Hold the previous beat so its trailing edge can be joined with it.
    always_ff @(posedge clk) begin
        if (vld_i) prev_q <= beat_i;
    end

    // Mark that a previous beat exists since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)     have_prev_q <= 1'b0;
        else if (vld_i) have_prev_q <= 1'b1;
    end

    for (genvar i = 0; i < BEAT_BITS; i++) begin : g_bit
        assign dat_o[i] = prev_q[2*i+1];
        if (i < BEAT_BITS-1) begin : g_inner
            assign edg_o[i] = prev_q[2*(i+1)];
        end else begin : g_cross
            assign edg_o[i] = beat_i[0];
        end
    end

    assign vld_o = vld_i & have_prev_q;
endmodule

// File: rtl/ovs_gather.sv
// Module: one deserialization stage, collecting RATIO consecutive input
// slices of a data lane and an edge lane into a wider registered pair.
// Assumes inputs arrive with vld_i; slice 0 lands in the low bits.
module ovs_gather #(
    parameter int IN_W  = 2,
    parameter int RATIO = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IN_W-1:0]       dat_i,
    input  logic [IN_W-1:0]       edg_i,
    input  logic                  vld_i,
    output logic [IN_W*RATIO-1:0] dat_o,
    output logic [IN_W*RATIO-1:0] edg_o,
    output logic                  vld_o
);
    localparam int CNT_W  = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam int HOLD_W = IN_W*(RATIO-1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO-1);

    logic [CNT_W-1:0]  slot_q;
    logic [HOLD_W-1:0] dhold_q;
    logic [HOLD_W-1:0] ehold_q;

    // Slot counter: walks 0..RATIO-1 once per collected group.
    always_ff @(posedge clk) begin
        if (!rst_n)     slot_q <= '0;
        else if (vld_i) slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end

    // Store every slice except the last one of a group.
    always_ff @(posedge clk) begin
        if (vld_i && slot_q != LAST) begin
            dhold_q[slot_q*IN_W +: IN_W] <= dat_i;
            ehold_q[slot_q*IN_W +: IN_W] <= edg_i;
        end
    end

    // Present the full group and a one-cycle strobe on the last slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_o <= '0;
            edg_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i && (slot_q == LAST);
            if (vld_i && slot_q == LAST) begin
                dat_o <= {dat_i, dhold_q};
                edg_o <= {edg_i, ehold_q};
            end
        end
    end
endmodule

// File: rtl/ovs_deser.sv
// Module: top of the oversampled alignment deserializer. Retimes the beat,
// aligns edges to data, then deserializes 2:4 and 1:5 into word pairs.
// Assumes one beat per clock with no gaps after reset release.
module ovs_deser
    import ovs_deser_pkg::*;
#(
    parameter int BEAT_BITS  = DEF_BEAT_BITS,
    parameter int MID_RATIO  = DEF_MID_RATIO,
    parameter int WORD_RATIO = DEF_WORD_RATIO,
    localparam int SAMP_W    = SAMPLES_PER_BIT*BEAT_BITS,
    localparam int MID_W     = BEAT_BITS*MID_RATIO,
    localparam int WORD_W    = MID_W*WORD_RATIO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SAMP_W-1:0] samp_i,
    output logic [WORD_W-1:0] data_word_o,
    output logic [WORD_W-1:0] edge_word_o,
    output logic              word_valid_o
);
    logic [SAMP_W-1:0]    rs_beat;
    logic                 rs_vld;
    logic [BEAT_BITS-1:0] al_dat;
    logic [BEAT_BITS-1:0] al_edg;
    logic                 al_vld;
    logic [MID_W-1:0]     mid_dat;
    logic [MID_W-1:0]     mid_edg;
    logic                 mid_vld;

    ovs_resync #(.W(SAMP_W)) u_resync (
        .clk(clk), .rst_n(rst_n), .beat_i(samp_i),
        .beat_o(rs_beat), .vld_o(rs_vld)
    );

    ovs_align #(.BEAT_BITS(BEAT_BITS)) u_align (
        .clk(clk), .rst_n(rst_n), .beat_i(rs_beat), .vld_i(rs_vld),
        .dat_o(al_dat), .edg_o(al_edg), .vld_o(al_vld)
    );

    ovs_gather #(.IN_W(BEAT_BITS), .RATIO(MID_RATIO)) u_mid (
        .clk(clk), .rst_n(rst_n), .dat_i(al_dat), .edg_i(al_edg),
        .vld_i(al_vld), .dat_o(mid_dat), .edg_o(mid_edg), .vld_o(mid_vld)
    );

    ovs_gather #(.IN_W(MID_W), .RATIO(WORD_RATIO)) u_word (
        .clk(clk), .rst_n(rst_n), .dat_i(mid_dat), .edg_i(mid_edg),
        .vld_i(mid_vld), .dat_o(data_word_o), .edg_o(edge_word_o),
        .vld_o(word_valid_o)
    );
endmodule

// File: rtl/ovs_deser_chk.sv
// Module: assertion checker for ovs_deser, attached by bind.
// Assumes a beat every cycle after reset release, as the top does.
module ovs_deser_chk #(
    parameter int WORD_W     = 20,
    parameter int BEATS_WORD = 10,
    localparam int FIRST     = BEATS_WORD + 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] data_word_o,
    input logic [WORD_W-1:0] edge_word_o,
    input logic              word_valid_o
);
    logic [7:0] since_q;
    logic [7:0] gap_q;
    logic       seen_q;

    // Cycles since reset release, saturating past the first-word point.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_q <= '0;
        else if (since_q < 8'(FIRST)) since_q <= since_q + 8'd1;
    end

    // Cycles since the last strobe, plus a flag that one has occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (word_valid_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 8'hff) begin
            gap_q  <= gap_q + 8'd1;
        end
    end

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o);

    assert_word_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && seen_q) |-> (gap_q == 8'(BEATS_WORD-1)));

    assert_no_early_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q < 8'(FIRST)) |-> !word_valid_o);

    assert_first_word_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 8'(FIRST) && !seen_q) |-> word_valid_o);

    assert_words_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(data_word_o) || !$stable(edge_word_o)) |-> word_valid_o);
endmodule

bind ovs_deser ovs_deser_chk #(.WORD_W(WORD_W), .BEATS_WORD(MID_RATIO*WORD_RATIO)) u_chk (
    .clk(clk), .rst_n(rst_n), .data_word_o(data_word_o),
    .edge_word_o(edge_word_o), .word_valid_o(word_valid_o)
);

// File: tb/ovs_deser_tb.sv
module ovs_deser_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  samp_i = '0;
    logic [19:0] data_word_o;
    logic [19:0] edge_word_o;
    logic        word_valid_o;

    int checks = 0;
    int fails  = 0;
    logic [3:0] beats [0:511];

    always #5 clk = ~clk;

    ovs_deser u_dut (
        .clk(clk), .rst_n(rst_n), .samp_i(samp_i),
        .data_word_o(data_word_o), .edge_word_o(edge_word_o),
        .word_valid_o(word_valid_o)
    );

    // Expected data word k: stream bit j is beat j/2, sample 1 or 3 (R1).
    function automatic logic [19:0] exp_data(int k);
        logic [19:0] w;
        for (int i = 0; i < 20; i++) begin
            int j = 20*k + i;
            w[i] = beats[j/2][(j%2) ? 3 : 1];
        end
        return w;
    endfunction

    // Expected edge word k: edge before stream bit j+1, sample 0 or 2 (R2).
    function automatic logic [19:0] exp_edge(int k);
        logic [19:0] w;
        for (int i = 0; i < 20; i++) begin
            int m = 20*k + i + 1;
            w[i] = beats[m/2][(m%2) ? 2 : 0];
        end
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Fill beat table: random blocks mixed with directed patterns.
    task automatic fill(input int flavour);
        for (int b = 0; b < 512; b++) begin
            int seg = (b / 24 + flavour) % 6;
            case (seg)
                0: beats[b] = 4'h0;
                1: beats[b] = 4'hf;
                2: beats[b] = 4'b1010;
                3: beats[b] = (b % 7 == 0) ? 4'b0010 : 4'b0000;
                4: beats[b] = 4'b0101;
                default: beats[b] = 4'($urandom);
            endcase
        end
    endtask

    // Run one stream of ncyc cycles from reset release, checking each word.
    task automatic run_stream(input int ncyc, input string tag);
        int words = 0;
        int last  = -1;
        logic [19:0] hd = '0;
        logic [19:0] he = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(word_valid_o == 1'b0 && data_word_o == '0 && edge_word_o == '0,
              "R5 reset state", {11'b0, word_valid_o, data_word_o}, 32'h0);
        rst_n  = 1'b1;
        samp_i = beats[0];
        for (int cyc = 0; cyc < ncyc; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            if (word_valid_o) begin
                if (last < 0) begin
                    check(cyc == 13, {"R3 first word edge ", tag}, cyc, 13);
                    check(1'b1, "R5 no strobe before first word", 0, 0);
                end else begin
                    check(cyc - last == 10, {"R4 strobe spacing ", tag}, cyc - last, 10);
                end
                check(data_word_o == exp_data(words), {"R1 data word ", tag},
                      {12'b0, data_word_o}, {12'b0, exp_data(words)});
                check(edge_word_o == exp_edge(words), {"R2 edge word ", tag},
                      {12'b0, edge_word_o}, {12'b0, exp_edge(words)});
                hd = data_word_o;
                he = edge_word_o;
                last = cyc;
                words++;
            end else begin
                if (last < 0 && cyc < 13) begin
                    // strobe correctly low before first word (R5)
                end else if (last < 0) begin
                    check(1'b0, "R5 strobe missing", 0, 1);
                end else begin
                    check(data_word_o == hd && edge_word_o == he, {"R6 hold ", tag},
                          {12'b0, data_word_o}, {12'b0, hd});
                end
                if (last >= 0) check(cyc - last < 10, {"R4 strobe late ", tag}, cyc - last, 10);
            end
            samp_i = beats[cyc+1];
        end
        check(words == (ncyc - 14) / 10 + 1, {"R4 word count ", tag}, words, (ncyc - 14) / 10 + 1);
    endtask

    initial begin
        void'($urandom(32'h5eed_0017));
        fill(0);
        run_stream(300, "A");
        // mid-word reset: run a partial stream, then restart (R7)
        fill(3);
        run_stream(57, "partial");
        fill(5);
        run_stream(200, "R7 restart");
        fill(1);
        run_stream(140, "B");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule